// File: doc/BRIEF.md
# Timer Count-Enable Prescaler

This block decides, cycle by cycle, whether a timer counter may advance. It lives entirely in the bus clock domain. It emits a one-cycle count-enable strobe that a downstream counter uses as its increment qualifier. A 7-bit control word picks where count events come from. The source is either every bus-clock cycle, or transitions of a slow external clock pin, rising or falling as chosen. The word can also thin those events by a power of two.

The external pin passes through a two-stage synchroniser and an edge detector. Each detected edge becomes exactly one event. The pin must toggle at under half the bus clock rate. A 17-bit event counter implements the division. A strobe leaves whenever the low N+1 bits of that counter roll over from all ones. Software loads the control word through a plain write strobe with no address, and the current value is always visible on a readback port.

Top module: `tcp_count_enable`

## Requirements
- R1: The control word resets to 0x00. A write with `wr_en` high loads all 7 bits of `wr_data`, and `rd_data` shows the new value from the next cycle on.
- R2: With bit 5 = 0 (bus source) and bit 0 = 0 (no division), `cnt_en` is high in every cycle that follows a non-write, non-reset cycle.
- R3: With bit 0 = 1, and N taken from bits 4:1, exactly one strobe is issued per 2^(N+1) events. This covers N = 0 (divide by 2) through N = 15 (divide by 65536).
- R4: The strobe is registered. The event in the cycle before clock edge k (counting the cycle after a write as the first event) leads to `cnt_en` high in the cycle after edge k. With division, that event must be the 2^(N+1)-th event since the last write or wrap.
- R5: With bit 5 = 1 and bit 6 = 0, rising edges of `ext_clk` are events. A transition applied before edge k gives its strobe in the cycle after edge k+2. Each edge gives one event only.
- R6: With bit 5 = 1 and bit 6 = 1, falling edges of `ext_clk` are the events, and rising edges produce nothing.
- R7: While bit 5 = 0, the value of bit 6 changes nothing about `cnt_en`.
- R8: A write clears the event counter and suppresses `cnt_en` for the cycle after the write. This holds even when that cycle would otherwise have carried a wrap strobe.
- R9: While `rst` is high, `cnt_en` is low and the control word, synchroniser, edge history and event counter return to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 7 | Control word to load: [6] falling-edge select, [5] external source, [4:1] exponent N, [0] divide enable |
| rd_data | output | 7 | Current control word |
| ext_clk | input | 1 | Asynchronous external count clock |
| cnt_en | output | 1 | One-cycle count-enable strobe |

## Verification
The collision that matters is a write landing in the same cycle as a prescaler wrap. In that cycle, clearing the counter and issuing a strobe compete. The bench provokes this directly. It writes a divide-by-4 word, lets exactly three events pass, and then writes again on the edge that carries the fourth event. It expects no strobe in the following cycle and a fresh full period of four events afterwards. Random writes mixed with external toggles reach the same collision in bus and external modes, and a cycle-accurate reference model built from the requirements judges every cycle.

// File: rtl/tcp_pkg.sv
package tcp_pkg;

    localparam int EXP_W = 4;
    localparam int CNT_W = (1 << EXP_W) + 1;
    localparam int CFG_W = 7;

    typedef struct packed {
        logic             ext_fall;
        logic             ext_src;
        logic [EXP_W-1:0] div_exp;
        logic             div_en;
    } ctrl_t;

    function automatic logic [CNT_W-1:0] wrap_mask(input logic [EXP_W-1:0] n);
        logic [CNT_W-1:0] m;
        m = '0;
        for (int i = 0; i < CNT_W; i++) begin
            if (i <= int'(n)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/tcp_ctl_reg.sv
module tcp_ctl_reg
    import tcp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output ctrl_t            cfg
);

    always_ff @(posedge clk) begin
        if (rst)        cfg <= '0;
        else if (wr_en) cfg <= ctrl_t'(wr_data);
    end

    AST_READBACK: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (cfg == ctrl_t'($past(wr_data)))); // R1

endmodule

// File: rtl/tcp_edge_src.sv
module tcp_edge_src #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_in,
    input  logic fall_sel,
    output logic edge_ev
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   hist_q;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            hist_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], ext_in};
            hist_q <= synced;
        end
    end

    assign edge_ev = fall_sel ? (~synced & hist_q) : (synced & ~hist_q);

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (edge_ev && $stable(fall_sel)) |=> !edge_ev); // R5

endmodule

// File: rtl/tcp_prescaler.sv
module tcp_prescaler
    import tcp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             ev,
    input  logic             div_en,
    input  logic [EXP_W-1:0] div_exp,
    output logic             pulse
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mask;
    logic             at_wrap;

    assign mask    = wrap_mask(div_exp);
    assign at_wrap = (cnt_q & mask) == mask;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
            pulse <= 1'b0;
        end else if (ev) begin
            cnt_q <= cnt_q + 1'b1;
            pulse <= !div_en || at_wrap;
        end else begin
            pulse <= 1'b0;
        end
    end

    AST_WRAP_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (pulse && div_en) |-> ((cnt_q & mask) == '0)); // R4

    AST_WRITE_SUPPRESS: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!pulse && cnt_q == '0)); // R8

endmodule

// File: rtl/tcp_count_enable.sv
module tcp_count_enable
    import tcp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] rd_data,
    input  logic             ext_clk,
    output logic             cnt_en
);

    ctrl_t cfg;
    logic  edge_ev;
    logic  src_ev;

    tcp_ctl_reg u_ctl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    tcp_edge_src #(.SYNC_STAGES(2)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .ext_in   (ext_clk),
        .fall_sel (cfg.ext_fall),
        .edge_ev  (edge_ev)
    );

    assign src_ev = cfg.ext_src ? edge_ev : 1'b1;

    tcp_prescaler u_pre (
        .clk     (clk),
        .rst     (rst),
        .clr     (wr_en),
        .ev      (src_ev),
        .div_en  (cfg.div_en),
        .div_exp (cfg.div_exp),
        .pulse   (cnt_en)
    );

    assign rd_data = cfg;

    AST_BUS_EVERY_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (!cfg.ext_src && !cfg.div_en && !wr_en) |=> cnt_en); // R2

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !cnt_en); // R9

endmodule

// File: tb/tcp_count_enable_tb.sv
module tcp_count_enable_tb;
    import tcp_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [6:0] wr_data = '0;
    logic [6:0] rd_data;
    logic       ext_clk = 1'b0;
    logic       cnt_en;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R9";

    ctrl_t            m_cfg;
    logic [CNT_W-1:0] m_cnt;
    logic             m_s1, m_s2, m_h, m_exp;

    always #2.5 clk = ~clk;

    tcp_count_enable u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .ext_clk(ext_clk), .cnt_en(cnt_en)
    );

    function automatic logic [CNT_W-1:0] bmask(input logic [3:0] n);
        return CNT_W'((64'd1 << (int'(n) + 1)) - 64'd1);
    endfunction

    task automatic model_edge();
        logic ev;
        if (rst) begin
            m_cfg = '0; m_cnt = '0; m_s1 = 0; m_s2 = 0; m_h = 0; m_exp = 0;
        end else begin
            if (m_cfg.ext_src) ev = m_cfg.ext_fall ? (!m_s2 && m_h) : (m_s2 && !m_h);
            else ev = 1'b1;
            if (wr_en) begin
                m_exp = 0; m_cnt = '0; m_cfg = ctrl_t'(wr_data);
            end else if (ev) begin
                m_exp = !m_cfg.div_en || ((m_cnt & bmask(m_cfg.div_exp)) == bmask(m_cfg.div_exp));
                m_cnt = m_cnt + 1'b1;
            end else begin
                m_exp = 0;
            end
            m_h = m_s2; m_s2 = m_s1; m_s1 = ext_clk;
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, expv, $time);
        end
    endtask

    task automatic cyc(input logic w, input logic [6:0] d, input logic e);
        wr_en = w; wr_data = d; ext_clk = e;
        model_edge();
        @(posedge clk);
        @(negedge clk);
        check(cur_req, {31'd0, cnt_en}, {31'd0, m_exp});
        check("R1", {25'd0, rd_data}, {25'd0, m_cfg});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, '0, ext_clk);
    endtask

    task automatic wr(input logic [6:0] d);
        cyc(1'b1, d, ext_clk);
    endtask

    task automatic ext_run(input int edges, input int half);
        for (int i = 0; i < edges; i++) begin
            for (int j = 0; j < half; j++) cyc(1'b0, '0, 1'b1);
            for (int j = 0; j < half; j++) cyc(1'b0, '0, 1'b0);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(190000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    initial begin
        int pulses;
        int hold;
        logic [6:0] rd_;
        @(negedge clk);
        // R9: reset holds outputs low
        cur_req = "R9";
        for (int i = 0; i < 3; i++) cyc(1'b0, 7'h7F, 1'b1);
        cyc(1'b1, 7'h55, 1'b0);
        rst = 1'b0;
        ext_clk = 1'b0;

        // R2: bus source, no division
        cur_req = "R2";
        wr(7'h00); idle(10);

        // R3: divide by 2 and by 16
        cur_req = "R3";
        wr(7'h01); idle(20);
        wr(7'h07); idle(40);

        // R7: bit 6 has no effect with bus source
        cur_req = "R7";
        wr(7'h40); idle(10);
        wr(7'h47); idle(40);

        // R5: rising external edges
        cur_req = "R5";
        wr(7'h20); ext_run(8, 3); idle(4);
        // R6: falling external edges
        cur_req = "R6";
        wr(7'h60); ext_run(8, 4); idle(4);
        // R4: external source divided by 4
        cur_req = "R4";
        wr(7'h23); ext_run(12, 3); idle(4);

        // R8: write clears counter; write collides with wrap
        cur_req = "R8";
        wr(7'h07); idle(10); wr(7'h07); idle(40);
        wr(7'h03); idle(3); wr(7'h03); idle(12);

        // R3: largest divisor 65536
        cur_req = "R3";
        wr(7'h1F);
        pulses = 0;
        for (int i = 0; i < 65540; i++) begin
            cyc(1'b0, '0, 1'b0);
            if (cnt_en) pulses++;
        end
        check("R3", pulses, 1);

        // R9: reset mid-run
        cur_req = "R9";
        wr(7'h00); idle(3);
        rst = 1'b1; idle(3); rst = 1'b0;
        rd_ = rd_data;
        check("R9", {25'd0, rd_}, 32'd0);

        // R4: random mix
        cur_req = "R4";
        void'($urandom(32'd20240611));
        hold = 0;
        for (int i = 0; i < 4000; i++) begin
            logic e;
            e = ext_clk;
            if (hold >= 2 && ($urandom % 3) == 0) begin
                e = ~ext_clk; hold = 0;
            end else hold++;
            if (($urandom % 60) == 0) begin
                logic [6:0] d;
                d = 7'($urandom);
                if (($urandom % 2) == 0) d[4:1] = 4'($urandom % 3);
                cyc(1'b1, d, e);
            end else begin
                cyc(1'b0, '0, e);
            end
        end
        summary();
    end

endmodule